// File: doc/BRIEF.md
# Quad Output Read Flash Responder

This block plays the device side of a serial flash read. It oversamples chip select, the serial clock and data line IO0 with a system clock. It shifts in a command of 40 bits: an 8-bit opcode, a 24-bit byte address and 8 dummy bits. If the command is the quad output read and the device may answer it, the block returns stored bytes four bits at a time on four I/O lines. It returns the upper nibble first, then the lower nibble.

The stored bytes come from a small synchronous array of 2^ADDR_W bytes. Only the low ADDR_W bits of the received address are used. The read address steps forward after each full byte and wraps to zero past the top. The read is refused when the device reports a busy program, erase or register-write operation, or when the quad-enable configuration bit is clear. It is also refused for any other opcode. A refused command leaves the lines undriven until the next deselect.

Top module: `qor_responder`

## Requirements
- R1: While cs_n is low, each rising SCK edge latches io0 into the command, most significant bit first. The order is opcode (8'h6B is the read), then the 24-bit address, then 8 dummy bits.
- R2: io_oe stays low through the 40 command clocks. It first rises on the SCK falling edge that follows the 40th rising edge.
- R3: Each byte is sent as two nibbles, bits 7..4 first and then bits 3..0. Bit 7 and bit 3 appear on io_o[3]. io_o changes only after a falling SCK edge.
- R4: After both nibbles of a byte have been sent, the array address advances by one. Output continues for as long as SCK toggles.
- R5: After the byte at the highest array address (2^ADDR_W-1), the next byte comes from address 0.
- R6: cs_n high forces io_oe low by the next system clock. It also clears the bit counter and nibble phase, so the next selection decodes a fresh opcode and starts with an upper nibble.
- R7: When busy is high at the 8th rising SCK edge, the read is refused and io_oe stays low until cs_n rises.
- R8: When quad_en is low at the 8th rising SCK edge, the read is refused and io_oe stays low until cs_n rises.
- R9: Any opcode other than 8'h6B leaves io_oe low until cs_n rises.
- R10: The array byte at address a holds (a*37 + 8'h5A) modulo 256.
- R11: After reset io_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| io0 | input | 1 | Serial command and address input |
| quad_en | input | 1 | Quad-enable configuration bit |
| busy | input | 1 | Program, erase or register write in progress |
| io_o | output | 4 | Nibble driven on IO3..IO0 |
| io_oe | output | 1 | Output enable for all four I/O lines |

## Verification
Suppose the bit counter is off by one. Then io_oe rises one SCK clock early or late, and the first data edge shows it: it is seen as drive during the command, or as a missing nibble at the 41st rising edge. A stuck nibble phase or address counter shows up within two data clocks, as swapped nibbles or a repeated byte. A stale accept or refuse decision shows on the first data clock of the following transaction. A wrap error appears on the byte right after address 2^ADDR_W-1.

// File: rtl/qor_responder.sv
module qor_responder #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  RD_OP    = 8'h6B,
  parameter logic [7:0]  FILL_MUL = 8'd37,
  parameter logic [7:0]  FILL_ADD = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       io0,
  input  logic       quad_en,
  input  logic       busy,
  output logic [3:0] io_o,
  output logic       io_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SRW   = (ADDR_W - 1 > 7) ? ADDR_W - 1 : 7;
  localparam logic [5:0] LAST = 6'd40;

  logic [7:0]        mem [DEPTH];
  logic [7:0]        rd_data;
  logic [SRW-1:0]    sr;
  logic [ADDR_W-1:0] addr;
  logic [5:0]        cnt;
  logic              sck_q, rej, half;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i) * FILL_MUL + FILL_ADD;

  always_ff @(posedge clk) rd_data <= mem[addr];

  wire rise  = sck & ~sck_q;
  wire fall  = ~sck & sck_q;
  wire drive = fall && !cs_n && cnt == LAST && !rej;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cnt   <= '0;
      sr    <= '0;
      addr  <= '0;
      rej   <= 1'b0;
      half  <= 1'b0;
      io_o  <= '0;
      io_oe <= 1'b0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        cnt   <= '0;
        rej   <= 1'b0;
        half  <= 1'b0;
        io_oe <= 1'b0;
      end else begin
        if (rise && cnt != LAST) begin
          cnt <= cnt + 6'd1;
          sr  <= {sr[SRW-2:0], io0};
          if (cnt == 6'd7 && ({sr[6:0], io0} != RD_OP || !quad_en || busy))
            rej <= 1'b1;
          if (cnt == 6'd31)
            addr <= {sr[ADDR_W-2:0], io0};
        end
        if (drive) begin
          io_oe <= 1'b1;
          half  <= ~half;
          if (!half) io_o <= rd_data[7:4];
          else begin
            io_o <= rd_data[3:0];
            addr <= addr + 1'b1;
          end
        end
      end
    end
  end

  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !io_oe);
  assert_enable_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_oe) |-> (cnt == LAST && !rej));
  assert_refused_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rej |-> !io_oe);
  assert_nibble_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(io_o));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && half) |=> addr == ADDR_W'($past(addr) + 1'b1));
endmodule

// File: tb/qor_responder_tb_top.sv
module qor_responder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, io0 = 1'b0;
  logic quad_en = 1'b1, busy = 1'b0, data_phase = 1'b0;
  logic [3:0] io_o;
  logic io_oe;
  int total = 0, bad = 0;
  logic [4:0] expq [$];

  always #10 clk = ~clk;

  qor_responder dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io0(io0),
    .quad_en(quad_en), .busy(busy), .io_o(io_o), .io_oe(io_oe));

  function automatic logic [7:0] fill(input logic [7:0] a);
    return 8'(a * 37 + 90); // R10 contents
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clock_bit(input logic b);
    @(negedge clk); sck = 1'b0; io0 = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // driver: pushes the expected nibbles, then clocks them out
  task automatic xfer(input logic [7:0] op, input logic [23:0] a, input int nib, input bit ok);
    logic [39:0] cmd;
    cmd = {op, a, 8'h00};
    for (int k = 0; k < nib; k++) begin
      logic [7:0] b;
      b = fill(8'(a[7:0] + 8'(k / 2)));
      expq.push_back({ok, (k % 2 == 0) ? b[7:4] : b[3:0]});
    end
    @(negedge clk); cs_n = 1'b0;
    for (int i = 39; i >= 0; i--) clock_bit(cmd[i]); // R1 msb first
    data_phase = 1'b1;
    for (int k = 0; k < nib; k++) clock_bit(1'b0);
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(io_oe == 1'b0, "R6 deselect idle", io_oe, 0);
    sck = 1'b0;
    repeat (4) @(negedge clk);
    data_phase = 1'b0;
    chk(expq.size() == 0, "R4 all nibbles seen", expq.size(), 0);
  endtask

  // monitor: compares at each rising SCK, where a host samples
  always @(posedge sck) begin
    if (data_phase) begin
      if (expq.size() == 0) chk(1'b0, "R4 unexpected data clock", 0, 1);
      else begin
        logic [4:0] e;
        e = expq.pop_front();
        if (e[4]) begin
          chk(io_oe == 1'b1, "R2 drive enabled", io_oe, 1);
          chk(io_o == e[3:0], "R3/R4/R5 nibble", io_o, e[3:0]);
        end else
          chk(io_oe == 1'b0, "R7/R8/R9 refused silent", io_oe, 0);
      end
    end else if (!cs_n)
      chk(io_oe == 1'b0, "R2 idle during command", io_oe, 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(io_oe == 1'b0, "R11 reset idle", io_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(io_oe == 1'b0, "R11 after reset", io_oe, 0);
    xfer(8'h6B, 24'h000010, 6, 1'b1);          // R1 R3 R4 R10
    xfer(8'h6B, 24'h1234FE, 8, 1'b1);          // R5 wrap FE,FF,00,01
    busy = 1'b1;
    xfer(8'h6B, 24'h000020, 4, 1'b0);          // R7
    busy = 1'b0; quad_en = 1'b0;
    xfer(8'h6B, 24'h000020, 4, 1'b0);          // R8
    quad_en = 1'b1;
    xfer(8'h0B, 24'h000020, 4, 1'b0);          // R9
    @(negedge clk); cs_n = 1'b0;               // R6 abort mid-command
    for (int i = 0; i < 20; i++) clock_bit(1'b1);
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(io_oe == 1'b0, "R6 abort command", io_oe, 0);
    sck = 1'b0; repeat (4) @(negedge clk);
    xfer(8'h6B, 24'h000081, 4, 1'b1);          // R6 fresh decode
    xfer(8'h6B, 24'h000040, 1, 1'b1);          // R6 abort after one nibble
    xfer(8'h6B, 24'h000041, 4, 1'b1);          // R6 upper nibble first again
    xfer(8'h6B, 24'h0000FF, 3, 1'b1);          // R5 FF then 00
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule